// File: doc/BRIEF.md
# Debug TAP data register selector

This block sits behind a JTAG-style debug test access port and owns every data register that the port can scan. A separate TAP controller supplies the Capture-DR, Shift-DR and Update-DR strobes, and a separate instruction register supplies the decoded instruction. From these the block picks the serial path that joins TDI to TDO. It holds these registers:

- a fixed implementation-code word;
- a 32-bit processor-access address register;
- a 32-bit data register;
- a debug control register;
- a one-bit bypass stage;
- a one-bit fast-data stage.

Capture-DR is the only read. On that edge the block loads parallel values from the processor-access logic into the selected shift stages. Update-DR is the only write. On that edge the shifted contents move into holding registers, and those registers drive the processor-access logic. One instruction links the address, data and control registers into a single 96-bit path. The fast-data instruction places the processor-access-pending flag in front of the data register, so that a debugger can poll the flag and move a data word in one scan. Bits leave at TDO least significant first, and TDO changes only on the falling edge of TCK.

Top module: `dbg_dr_select`

## Requirements
- R1: While `trst_n` is low at a rising TCK edge, the address, data and control holding registers take their reset parameter values (all zero by default). TDO is 0 after a falling edge with reset low.
- R2: Instruction code 0x03 selects a 32-bit path. Capture-DR loads the constant IMPL_CODE (default 0x2A5C0107). Update-DR under this instruction leaves all holding registers unchanged.
- R3: Instruction code 0x08 selects the 32-bit address path. Capture-DR loads `addr_cap_i`. Update-DR copies the shifted word to `addr_o`.
- R4: Instruction code 0x09 selects the 32-bit data path. Capture-DR loads `data_cap_i`. Update-DR copies the shifted word to `data_o`.
- R5: Instruction code 0x0A selects the 32-bit control path. Capture-DR loads `ctrl_cap_i`. Update-DR copies the shifted word to `ctrl_o`.
- R6: Instruction code 0x0B chains TDI, then address, then data, then control, then TDO, for 96 bits. The control bits leave first. Update-DR loads all three holding registers.
- R7: Instruction code 0x0E gives a 33-bit path. Its first bit out is `ctrl_cap_i[18]`, the pending flag, taken at the Capture-DR edge. The 32 bits of `data_cap_i` follow. After 33 shifts the data register holds shifted-in bits 32..1. Update-DR changes only `data_o`.
- R8: The codes 0x1F, 0x0C and 0x0D, and every code not listed in R2 to R7, select a one-bit bypass path. It captures 0, and TDI reaches TDO one shift later. Update-DR leaves all holding registers unchanged.
- R9: Shift stages move only on rising TCK edges with Shift-DR high. Idle cycles between Capture-DR and Shift-DR lose no bit. TDO keeps its value across the rising edge and changes only on the falling edge.
- R10: Update-DR loads only the holding registers on the selected path. Without Update-DR every holding register keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Synchronous active-low test reset |
| capture_dr | input | 1 | TAP is in Capture-DR |
| shift_dr | input | 1 | TAP is in Shift-DR |
| update_dr | input | 1 | TAP is in Update-DR |
| instr | input | 5 | Current instruction code |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, falling-edge timed |
| addr_cap_i | input | 32 | Address value read at Capture-DR |
| data_cap_i | input | 32 | Data value read at Capture-DR |
| ctrl_cap_i | input | 32 | Control/status value read at Capture-DR; bit 18 is the pending flag |
| addr_o | output | 32 | Address holding register |
| data_o | output | 32 | Data holding register |
| ctrl_o | output | 32 | Control holding register |

## Verification
Under the fast-data instruction, two loads fall on the same Capture-DR edge: the pending flag into the one-bit stage and the processor word into the data register. In selected scans the bench flips the pending flag and the data input right after that edge, and it expects the pre-edge values at TDO in the first 33 bits. The chained instruction makes three Update-DR loads coincide. After that edge all three holding registers are compared with the 96 bits shifted in. Scans under other instructions then show that their holding registers stay untouched.

// File: rtl/dbg_dr_pkg.sv
`timescale 1ns/1ps
// Shared instruction codes, path selector type and decode function for the
// debug data register selector. Assumes a 5-bit instruction register.
package dbg_dr_pkg;
    localparam int IR_W = 5;

    localparam logic [IR_W-1:0] OP_IMPL    = 5'h03;
    localparam logic [IR_W-1:0] OP_ADDR    = 5'h08;
    localparam logic [IR_W-1:0] OP_DATA    = 5'h09;
    localparam logic [IR_W-1:0] OP_CTRL    = 5'h0A;
    localparam logic [IR_W-1:0] OP_ALL     = 5'h0B;
    localparam logic [IR_W-1:0] OP_DBGBOOT = 5'h0C;
    localparam logic [IR_W-1:0] OP_NRMBOOT = 5'h0D;
    localparam logic [IR_W-1:0] OP_FAST    = 5'h0E;
    localparam logic [IR_W-1:0] OP_BYPASS  = 5'h1F;

    typedef enum logic [2:0] {
        P_BYP  = 3'd0,
        P_IMPL = 3'd1,
        P_ADDR = 3'd2,
        P_DATA = 3'd3,
        P_CTRL = 3'd4,
        P_ALL  = 3'd5,
        P_FAST = 3'd6
    } path_e;

    // Map an instruction code to the scan path it selects.
    function automatic path_e decode_op(input logic [IR_W-1:0] op);
        path_e p;
        case (op)
            OP_IMPL:    p = P_IMPL;
            OP_ADDR:    p = P_ADDR;
            OP_DATA:    p = P_DATA;
            OP_CTRL:    p = P_CTRL;
            OP_ALL:     p = P_ALL;
            OP_FAST:    p = P_FAST;
            OP_DBGBOOT: p = P_BYP;
            OP_NRMBOOT: p = P_BYP;
            OP_BYPASS:  p = P_BYP;
            default:    p = P_BYP;
        endcase
        return p;
    endfunction
endpackage

// File: rtl/dbg_dr_decode.sv
`timescale 1ns/1ps
// Instruction decoder: turns the instruction code into a path selector and
// one enable per register group. Purely combinational; it assumes the
// instruction is stable for a whole capture/shift/update sequence.
module dbg_dr_decode
    import dbg_dr_pkg::*;
(
    input  logic [IR_W-1:0] instr,
    output path_e           path,
    output logic            en_impl,
    output logic            en_addr,
    output logic            en_data,
    output logic            en_ctrl,
    output logic            en_fast,
    output logic            en_byp
);
    // Select the path and the registers it contains.
    always_comb begin
        path    = decode_op(instr);
        en_impl = (path == P_IMPL);
        en_addr = (path == P_ADDR) || (path == P_ALL);
        en_data = (path == P_DATA) || (path == P_ALL) || (path == P_FAST);
        en_ctrl = (path == P_CTRL) || (path == P_ALL);
        en_fast = (path == P_FAST);
        en_byp  = (path == P_BYP);
    end

    // Bypass excludes every other register group (R8).
    always_comb begin
        a_r8_byp_alone: assert (!(en_byp && (en_impl || en_addr || en_data || en_ctrl || en_fast)))
            else $error("bypass selected together with another register");
    end
endmodule

// File: rtl/dbg_dr_shreg.sv
`timescale 1ns/1ps
// Capture/shift/update register: a W-bit shift stage that loads a parallel
// value on capture, shifts right (LSB toward TDO) on shift, and copies into
// a holding register on update. Assumes W >= 2 and one-hot use of the
// strobes by the TAP controller; capture wins over shift.
module dbg_dr_shreg #(
    parameter int          W       = 32,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         tck,
    input  logic         rst_n,
    input  logic         cap_en,
    input  logic         sh_en,
    input  logic         upd_en,
    input  logic         sin,
    input  logic [W-1:0] par_i,
    output logic [W-1:0] hold_o,
    output logic         sout
);
    logic [W-1:0] sr_q;
    logic [W-1:0] hold_q;

    // Shift stage: parallel load on capture, move one bit on shift.
    always_ff @(posedge tck) begin
        if (!rst_n)      sr_q <= '0;
        else if (cap_en) sr_q <= par_i;
        else if (sh_en)  sr_q <= {sin, sr_q[W-1:1]};
    end

    // Holding register: written only on update.
    always_ff @(posedge tck) begin
        if (!rst_n)      hold_q <= RST_VAL;
        else if (upd_en) hold_q <= sr_q;
    end

    assign hold_o = hold_q;
    assign sout   = sr_q[0];

    a_r3_capture_loads: assert property (@(posedge tck) disable iff (!rst_n)
        rst_n && cap_en |=> sr_q == $past(par_i));
    a_r9_idle_holds: assert property (@(posedge tck) disable iff (!rst_n)
        rst_n && !cap_en && !sh_en |=> $stable(sr_q));
    a_r9_shift_moves: assert property (@(posedge tck) disable iff (!rst_n)
        rst_n && sh_en && !cap_en |=> sr_q == {$past(sin), $past(sr_q[W-1:1])});
    a_r10_hold_kept: assert property (@(posedge tck) disable iff (!rst_n)
        rst_n && !upd_en |=> $stable(hold_q));
    a_r10_hold_loads: assert property (@(posedge tck) disable iff (!rst_n)
        rst_n && upd_en |=> hold_q == $past(sr_q));
endmodule

// File: rtl/dbg_dr_tdo.sv
`timescale 1ns/1ps
// TDO stage: picks the serial output of the selected path and retimes it on
// the falling edge of TCK. Assumes the path selector is stable while shifting.
module dbg_dr_tdo
    import dbg_dr_pkg::*;
(
    input  logic  tck,
    input  logic  rst_n,
    input  path_e path,
    input  logic  impl_b,
    input  logic  addr_b,
    input  logic  data_b,
    input  logic  ctrl_b,
    input  logic  fast_b,
    input  logic  byp_b,
    output logic  tdo
);
    logic sel_b;
    logic live_q;

    // Choose the bit nearest TDO on the active path.
    always_comb begin
        case (path)
            P_IMPL:  sel_b = impl_b;
            P_ADDR:  sel_b = addr_b;
            P_DATA:  sel_b = data_b;
            P_CTRL:  sel_b = ctrl_b;
            P_ALL:   sel_b = ctrl_b;
            P_FAST:  sel_b = fast_b;
            default: sel_b = byp_b;
        endcase
    end

    // Falling-edge output flop.
    always_ff @(negedge tck) begin
        if (!rst_n) tdo <= 1'b0;
        else        tdo <= sel_b;
    end

    // Marks falling edges that follow at least one out-of-reset falling edge.
    always_ff @(negedge tck) begin
        if (!rst_n) live_q <= 1'b0;
        else        live_q <= 1'b1;
    end

    a_r9_tdo_follows: assert property (@(negedge tck) disable iff (!rst_n)
        live_q |-> tdo == $past(sel_b));
endmodule

// File: rtl/dbg_dr_select.sv
`timescale 1ns/1ps
// Debug TAP data register selector (top). Holds the implementation-code,
// address, data, control, bypass and fast-data registers and joins the
// path chosen by the instruction between TDI and TDO. Assumes the TAP
// controller raises at most one of capture_dr/shift_dr/update_dr per cycle
// and keeps instr stable through a scan.
module dbg_dr_select
    import dbg_dr_pkg::*;
#(
    parameter int                 ADDR_W    = 32,
    parameter int                 DATA_W    = 32,
    parameter int                 CTRL_W    = 32,
    parameter int                 PRACC_BIT = 18,
    parameter logic [31:0]        IMPL_CODE = 32'h2A5C_0107,
    parameter logic [ADDR_W-1:0]  ADDR_RST  = '0,
    parameter logic [DATA_W-1:0]  DATA_RST  = '0,
    parameter logic [CTRL_W-1:0]  CTRL_RST  = '0
) (
    input  logic              tck,
    input  logic              trst_n,
    input  logic              capture_dr,
    input  logic              shift_dr,
    input  logic              update_dr,
    input  logic [IR_W-1:0]   instr,
    input  logic              tdi,
    output logic              tdo,
    input  logic [ADDR_W-1:0] addr_cap_i,
    input  logic [DATA_W-1:0] data_cap_i,
    input  logic [CTRL_W-1:0] ctrl_cap_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic [DATA_W-1:0] data_o,
    output logic [CTRL_W-1:0] ctrl_o
);
    localparam int IMPL_W = $bits(IMPL_CODE);

    path_e path;
    logic  en_impl, en_addr, en_data, en_ctrl, en_fast, en_byp;
    logic  addr_sout, data_sout, ctrl_sout;
    logic  data_sin, ctrl_sin;
    logic  chain_all;
    logic [IMPL_W-1:0] impl_sr;
    logic  fast_q;
    logic  byp_q;

    dbg_dr_decode u_decode (
        .instr   (instr),
        .path    (path),
        .en_impl (en_impl),
        .en_addr (en_addr),
        .en_data (en_data),
        .en_ctrl (en_ctrl),
        .en_fast (en_fast),
        .en_byp  (en_byp)
    );

    // Serial links: chained under ALL, otherwise each register fed from TDI.
    assign chain_all = (path == P_ALL);
    assign data_sin  = chain_all ? addr_sout : tdi;
    assign ctrl_sin  = chain_all ? data_sout : tdi;

    dbg_dr_shreg #(.W(ADDR_W), .RST_VAL(ADDR_RST)) u_addr (
        .tck    (tck),
        .rst_n  (trst_n),
        .cap_en (capture_dr && en_addr),
        .sh_en  (shift_dr && en_addr),
        .upd_en (update_dr && en_addr),
        .sin    (tdi),
        .par_i  (addr_cap_i),
        .hold_o (addr_o),
        .sout   (addr_sout)
    );

    dbg_dr_shreg #(.W(DATA_W), .RST_VAL(DATA_RST)) u_data (
        .tck    (tck),
        .rst_n  (trst_n),
        .cap_en (capture_dr && en_data),
        .sh_en  (shift_dr && en_data),
        .upd_en (update_dr && en_data),
        .sin    (data_sin),
        .par_i  (data_cap_i),
        .hold_o (data_o),
        .sout   (data_sout)
    );

    dbg_dr_shreg #(.W(CTRL_W), .RST_VAL(CTRL_RST)) u_ctrl (
        .tck    (tck),
        .rst_n  (trst_n),
        .cap_en (capture_dr && en_ctrl),
        .sh_en  (shift_dr && en_ctrl),
        .upd_en (update_dr && en_ctrl),
        .sin    (ctrl_sin),
        .par_i  (ctrl_cap_i),
        .hold_o (ctrl_o),
        .sout   (ctrl_sout)
    );

    // Implementation-code shift stage: loads the constant, no holding register.
    always_ff @(posedge tck) begin
        if (!trst_n)                   impl_sr <= '0;
        else if (capture_dr && en_impl) impl_sr <= IMPL_CODE;
        else if (shift_dr && en_impl)   impl_sr <= {tdi, impl_sr[IMPL_W-1:1]};
    end

    // Fast-data stage: takes the pending flag on capture, follows data on shift.
    always_ff @(posedge tck) begin
        if (!trst_n)                    fast_q <= 1'b0;
        else if (capture_dr && en_fast) fast_q <= ctrl_cap_i[PRACC_BIT];
        else if (shift_dr && en_fast)   fast_q <= data_sout;
    end

    // Bypass stage: clears on capture, passes TDI on shift.
    always_ff @(posedge tck) begin
        if (!trst_n)                   byp_q <= 1'b0;
        else if (capture_dr && en_byp) byp_q <= 1'b0;
        else if (shift_dr && en_byp)   byp_q <= tdi;
    end

    dbg_dr_tdo u_tdo (
        .tck    (tck),
        .rst_n  (trst_n),
        .path   (path),
        .impl_b (impl_sr[0]),
        .addr_b (addr_sout),
        .data_b (data_sout),
        .ctrl_b (ctrl_sout),
        .fast_b (fast_q),
        .byp_b  (byp_q),
        .tdo    (tdo)
    );

    a_r2_impl_capture: assert property (@(posedge tck) disable iff (!trst_n)
        trst_n && capture_dr && en_impl |=> impl_sr == IMPL_CODE);
    a_r7_fast_takes_flag: assert property (@(posedge tck) disable iff (!trst_n)
        trst_n && capture_dr && en_fast |=> fast_q == $past(ctrl_cap_i[PRACC_BIT]));
    a_r8_bypass_zero: assert property (@(posedge tck) disable iff (!trst_n)
        trst_n && capture_dr && en_byp |=> byp_q == 1'b0);
    a_r7_fast_follows_data: assert property (@(posedge tck) disable iff (!trst_n)
        trst_n && shift_dr && en_fast && !capture_dr |=> fast_q == $past(data_sout));
endmodule

// File: tb/dbg_dr_select_bench.sv
`timescale 1ns/100ps
// Scoreboard bench: the scan driver queues expected TDO bits, a monitor
// pops and compares them on every shifting rising edge.
module dbg_dr_select_bench;
    logic        tck = 1'b0;
    logic        trst_n = 1'b0;
    logic        capture_dr = 1'b0, shift_dr = 1'b0, update_dr = 1'b0;
    logic [4:0]  instr = 5'h1F;
    logic        tdi = 1'b0;
    logic        tdo;
    logic [31:0] addr_cap_i = '0, data_cap_i = '0, ctrl_cap_i = '0;
    logic [31:0] addr_o, data_o, ctrl_o;

    localparam logic [31:0] IMPL = 32'h2A5C_0107;

    int   nchk = 0;
    int   nerr = 0;
    logic exp_q[$];
    string tag_q[$];

    always #2 tck = ~tck;

    dbg_dr_select u_dbg_dr_select (
        .tck(tck), .trst_n(trst_n), .capture_dr(capture_dr), .shift_dr(shift_dr),
        .update_dr(update_dr), .instr(instr), .tdi(tdi), .tdo(tdo),
        .addr_cap_i(addr_cap_i), .data_cap_i(data_cap_i), .ctrl_cap_i(ctrl_cap_i),
        .addr_o(addr_o), .data_o(data_o), .ctrl_o(ctrl_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: compare TDO on each shift edge, and check TDO holds past the edge (R9).
    always @(posedge tck) begin
        logic v;
        string t;
        logic e;
        v = tdo;
        if (shift_dr) begin
            nchk++;
            if (exp_q.size() == 0) begin
                nerr++;
                $display("FAIL R9: unexpected shift bit actual=%b expected=none", v);
            end else begin
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (v !== e) begin
                    nerr++;
                    $display("FAIL %s: tdo actual=%b expected=%b", t, v, e);
                end
            end
            #0.5;
            chk("R9 tdo held past rising edge", {31'b0, tdo}, {31'b0, v});
        end
    end

    // One full scan: capture, optional idle gap, len shifts, update.
    task automatic scan(input logic [4:0] code, input int len, input logic [127:0] din,
                        input logic [127:0] dexp, input int gap, input bit flip, input string tag);
        @(negedge tck); #0.5;
        instr = code; capture_dr = 1'b1;
        @(negedge tck); #0.5;
        capture_dr = 1'b0;
        if (flip) begin
            ctrl_cap_i[18] = ~ctrl_cap_i[18];
            data_cap_i = ~data_cap_i;
        end
        for (int g = 0; g < gap; g++) begin
            @(negedge tck); #0.5;
        end
        for (int i = 0; i < len; i++) begin
            if (i > 0) begin
                @(negedge tck); #0.5;
            end
            shift_dr = 1'b1;
            tdi = din[i];
            exp_q.push_back(dexp[i]);
            tag_q.push_back(tag);
        end
        @(negedge tck); #0.5;
        shift_dr = 1'b0; update_dr = 1'b1;
        @(negedge tck); #0.5;
        update_dr = 1'b0;
    endtask

    initial begin
        #(200000 * 4);
        nerr++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", nerr, nchk + 1);
        $finish;
    end

    initial begin
        logic [31:0] a0, d0, c0;
        repeat (3) @(negedge tck);
        #0.5;
        // R1: reset values.
        chk("R1 addr reset", addr_o, 32'h0);
        chk("R1 data reset", data_o, 32'h0);
        chk("R1 ctrl reset", ctrl_o, 32'h0);
        chk("R1 tdo reset", {31'b0, tdo}, 32'h0);
        trst_n = 1'b1;

        // R2: implementation code, no holding change.
        scan(5'h03, 32, {96'b0, 32'hF00D_1234}, {96'b0, IMPL}, 0, 0, "R2");
        chk("R2 addr untouched", addr_o, 32'h0);
        chk("R2 data untouched", data_o, 32'h0);
        chk("R2 ctrl untouched", ctrl_o, 32'h0);

        // R3: address path.
        addr_cap_i = 32'h8000_1F40;
        scan(5'h08, 32, {96'b0, 32'hDEAD_BEEF}, {96'b0, 32'h8000_1F40}, 0, 0, "R3");
        chk("R3 addr updated", addr_o, 32'hDEAD_BEEF);
        chk("R10 data kept on addr update", data_o, 32'h0);

        // R4 with R9 idle gap after capture.
        data_cap_i = 32'h1357_9BDF;
        scan(5'h09, 32, {96'b0, 32'hA5A5_0F0F}, {96'b0, 32'h1357_9BDF}, 3, 0, "R4");
        chk("R4 data updated", data_o, 32'hA5A5_0F0F);
        chk("R10 addr kept on data update", addr_o, 32'hDEAD_BEEF);

        // R5: control path.
        ctrl_cap_i = 32'h0004_0011;
        scan(5'h0A, 32, {96'b0, 32'h0000_8003}, {96'b0, 32'h0004_0011}, 0, 0, "R5");
        chk("R5 ctrl updated", ctrl_o, 32'h0000_8003);
        chk("R10 data kept on ctrl update", data_o, 32'hA5A5_0F0F);

        // R6: chained path, 96 bits, control out first.
        addr_cap_i = 32'h0BAD_F00D; data_cap_i = 32'hC0DE_7E57; ctrl_cap_i = 32'h0000_0F0F;
        scan(5'h0B, 96, {32'b0, 32'h1111_2222, 32'h3333_4444, 32'h5555_6666},
             {32'b0, 32'h0BAD_F00D, 32'hC0DE_7E57, 32'h0000_0F0F}, 0, 0, "R6");
        chk("R6 addr updated", addr_o, 32'h1111_2222);
        chk("R6 data updated", data_o, 32'h3333_4444);
        chk("R6 ctrl updated", ctrl_o, 32'h5555_6666);

        // R7: fast data, flag set, inputs flipped right after capture.
        a0 = addr_o; c0 = ctrl_o;
        data_cap_i = 32'h7654_3210; ctrl_cap_i = 32'h0004_0000;
        scan(5'h0E, 33, {95'b0, 32'h9ABC_DEF0, 1'b1}, {95'b0, 32'h7654_3210, 1'b1}, 0, 1, "R7");
        chk("R7 data updated", data_o, 32'h9ABC_DEF0);
        chk("R7 addr untouched", addr_o, a0);
        chk("R7 ctrl untouched", ctrl_o, c0);

        // R7: fast data, flag clear.
        data_cap_i = 32'h0F1E_2D3C; ctrl_cap_i = 32'hFFFB_FFFF;
        scan(5'h0E, 33, {95'b0, 32'h4B5A_6978, 1'b0}, {95'b0, 32'h0F1E_2D3C, 1'b0}, 2, 1, "R7");
        chk("R7 data updated second", data_o, 32'h4B5A_6978);

        // R8: bypass codes, captured 0 then TDI delayed by one.
        a0 = addr_o; d0 = data_o; c0 = ctrl_o;
        scan(5'h1F, 3, {125'b0, 3'b101}, {125'b0, 3'b010}, 0, 0, "R8 bypass");
        scan(5'h0C, 3, {125'b0, 3'b011}, {125'b0, 3'b110}, 0, 0, "R8 boot dbg");
        scan(5'h0D, 3, {125'b0, 3'b110}, {125'b0, 3'b100}, 0, 0, "R8 boot nrm");
        scan(5'h05, 3, {125'b0, 3'b111}, {125'b0, 3'b110}, 0, 0, "R8 unused");
        chk("R8 addr untouched", addr_o, a0);
        chk("R8 data untouched", data_o, d0);
        chk("R8 ctrl untouched", ctrl_o, c0);

        repeat (3) @(negedge tck);
        chk("R9 all shift bits consumed", exp_q.size(), 32'd0);

        // R1: reset again restores defaults.
        #0.5; trst_n = 1'b0;
        repeat (2) @(negedge tck);
        #0.5;
        chk("R1 addr re-reset", addr_o, 32'h0);
        chk("R1 data re-reset", data_o, 32'h0);
        chk("R1 ctrl re-reset", ctrl_o, 32'h0);

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule